// File: doc/BRIEF.md
# Active Video Window Generator

This block derives a data-enable strobe and a vertical-blank flag for a raster video stream. It counts pixel clocks from the leading edge of horizontal sync, and lines from the leading edge of vertical sync. It then compares those counts against programmable bounds. The horizontal window is a half-open span between a start pixel and a stop pixel. The vertical blank is a span that begins at a programmable line offset and lasts a programmable number of lines. Two separate sets of vertical settings exist, one per field. The field flag chooses between them, and it is captured when vertical sync begins.

Software programs the bounds through a byte-wide write port. Each 16-bit pixel position is written as two bytes, low byte first. The value changes as a whole only when the high byte arrives. Every committed value, including the vertical settings, is held back until the next line begins. A line that is already being scanned therefore never changes shape partway through.

Top module: `actwin_gen`

## Requirements
- R1: `hcount` reads 0 in the cycle after a clock edge that samples `hsync_in` high while it was low at the previous edge. On every other edge it rises by one, saturating at 65535.
- R2: `vcount` reads 0 after an edge that samples a rising `vsync_in`. Otherwise it rises by one, saturating at 4095, on each edge that samples a rising `hsync_in`, and holds on all other edges.
- R3: `de_out` is high exactly when `hstart <= hcount < hstop` and `vblank_out` is low. With the reset bounds, a 1328-pixel line carries exactly 1024 data-enable cycles.
- R4: `vblank_out` is high exactly when `bstart <= vcount < bstart + blen`. The pair (`bstart`, `blen`) is field 0's set when the `field_in` level latched at the last vertical sync leading edge was 0, and field 1's set when it was 1. Changes of `field_in` at other times have no effect.
- R5: The write map is as follows: address 0 is hstart low, 1 is hstart high, 2 is hstop low, 3 is hstop high, 4 is field-0 blank start, 5 is field-0 blank length, 6 is field-1 blank start and 7 is field-1 blank length. Writes to addresses 8 to 15 change nothing.
- R6: A write to a low-byte address alone leaves the position in use unchanged.
- R7: A high-byte write commits {high byte, last low byte written to that position}, even when no low-byte write came just before it. The low byte staged at reset is the low byte of the reset value.
- R8: Every committed value takes effect at the next edge that samples a rising `hsync_in`. The line being scanned when the write occurs keeps the old bounds.
- R9: After reset, hstart is 274 and hstop is 1298, both fields use blank start 3 and length 30, and `hcount`, `vcount`, `de_out` and `vblank_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync, leading edge is rising |
| vsync_in | input | 1 | Vertical sync, leading edge is rising |
| field_in | input | 1 | Field flag, latched at vertical sync leading edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| de_out | output | 1 | Data enable |
| vblank_out | output | 1 | Vertical blank |
| hcount | output | 16 | Pixel count since line start |
| vcount | output | 12 | Line count since frame start |

## Verification
The hardest case to reach is a commit that lands while the pixel counter is inside the active window. If the new value were applied at once instead of at the line boundary, the enable would change shape partway through the line. The stimulus starts a short line and commits a smaller stop position while the count is still below the old stop. It then keeps `hsync_in` low so the scoreboard can watch the rest of that line keep the old bound. A high-byte-only write is reached by first committing a high byte that pushes the start out of the line, then committing a second high byte alone. This shows that the staged low byte survives.

// File: rtl/actwin_pkg.sv
package actwin_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 2 * BYTE_W;
  localparam int ADDR_W  = 4;
  localparam int N_WORDS = 2;
  localparam int N_BYTES = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_HSTART_LO = 4'd0,
    A_HSTART_HI = 4'd1,
    A_HSTOP_LO  = 4'd2,
    A_HSTOP_HI  = 4'd3,
    A_F0_BSTART = 4'd4,
    A_F0_BLEN   = 4'd5,
    A_F1_BSTART = 4'd6,
    A_F1_BLEN   = 4'd7
  } reg_addr_e;

  // half-open span test: first <= pos < last_excl
  function automatic logic in_span(input logic [31:0] pos, input logic [31:0] first,
                                   input logic [31:0] last_excl);
    return (pos >= first) && (pos < last_excl);
  endfunction

  function automatic logic [31:0] span_end(input logic [31:0] first, input logic [31:0] len);
    return first + len;
  endfunction
endpackage

// File: rtl/actwin_wordreg.sv
module actwin_wordreg #(
  parameter logic [15:0] RST_VAL = 16'd0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_lo,
  input  logic        wr_hi,
  input  logic [7:0]  din,
  input  logic        apply,
  output logic [15:0] act
);
  logic [7:0]  stage_lo;
  logic [15:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo <= RST_VAL[7:0];
      pend     <= RST_VAL;
      act      <= RST_VAL;
    end else begin
      if (apply) act <= pend;
      if (wr_lo) stage_lo <= din;
      if (wr_hi) pend <= {din, stage_lo};
    end
  end
endmodule

// File: rtl/actwin_bytereg.sv
module actwin_bytereg #(
  parameter logic [7:0] RST_VAL = 8'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic [7:0] din,
  input  logic       apply,
  output logic [7:0] act
);
  logic [7:0] pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= RST_VAL;
      act  <= RST_VAL;
    end else begin
      if (apply) act <= pend;
      if (wr) pend <= din;
    end
  end
endmodule

// File: rtl/actwin_counters.sv
module actwin_counters #(
  parameter int HCNT_W = 16,
  parameter int VCNT_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync,
  input  logic              vsync,
  input  logic              field,
  output logic              line_start,
  output logic              frame_start,
  output logic [HCNT_W-1:0] hcnt,
  output logic [VCNT_W-1:0] vcnt,
  output logic              field_q
);
  localparam logic [HCNT_W-1:0] HMAX = '1;
  localparam logic [VCNT_W-1:0] VMAX = '1;

  logic hs_q, vs_q;

  assign line_start  = hsync && !hs_q;
  assign frame_start = vsync && !vs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      hcnt    <= '0;
      vcnt    <= '0;
      field_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
      if (line_start)       hcnt <= '0;
      else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
      if (frame_start) begin
        vcnt    <= '0;
        field_q <= field;
      end else if (line_start && vcnt != VMAX) begin
        vcnt <= vcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/actwin_gen.sv
module actwin_gen
  import actwin_pkg::*;
#(
  parameter int VCNT_W     = 12,
  parameter int HSTART_RST = 274,
  parameter int HSTOP_RST  = 1298,
  parameter int BSTART_RST = 3,
  parameter int BLEN_RST   = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              field_in,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              de_out,
  output logic              vblank_out,
  output logic [15:0]       hcount,
  output logic [VCNT_W-1:0] vcount
);
  localparam logic [WORD_W-1:0] WRST [N_WORDS] = '{WORD_W'(HSTART_RST), WORD_W'(HSTOP_RST)};
  localparam logic [BYTE_W-1:0] BRST [N_BYTES] =
    '{BYTE_W'(BSTART_RST), BYTE_W'(BLEN_RST), BYTE_W'(BSTART_RST), BYTE_W'(BLEN_RST)};

  // named internal events for the checker
  logic line_start, frame_start, field_q;
  logic [WORD_W-1:0] word_act [N_WORDS];
  logic [BYTE_W-1:0] byte_act [N_BYTES];
  logic [WORD_W-1:0] hstart_act, hstop_act;
  logic [BYTE_W-1:0] bstart_sel, blen_sel;

  actwin_counters #(.HCNT_W(WORD_W), .VCNT_W(VCNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hsync(hsync_in), .vsync(vsync_in), .field(field_in),
    .line_start(line_start), .frame_start(frame_start),
    .hcnt(hcount), .vcnt(vcount), .field_q(field_q)
  );

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    logic hit_lo, hit_hi;
    assign hit_lo = wr_en && (wr_addr == ADDR_W'(2 * k));
    assign hit_hi = wr_en && (wr_addr == ADDR_W'(2 * k + 1));
    actwin_wordreg #(.RST_VAL(WRST[k])) u_word (
      .clk(clk), .rst_n(rst_n), .wr_lo(hit_lo), .wr_hi(hit_hi),
      .din(wr_data), .apply(line_start), .act(word_act[k])
    );
  end

  for (genvar j = 0; j < N_BYTES; j++) begin : g_byte
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(A_F0_BSTART + j));
    actwin_bytereg #(.RST_VAL(BRST[j])) u_byte (
      .clk(clk), .rst_n(rst_n), .wr(hit), .din(wr_data),
      .apply(line_start), .act(byte_act[j])
    );
  end

  assign hstart_act = word_act[0];
  assign hstop_act  = word_act[1];
  assign bstart_sel = field_q ? byte_act[2] : byte_act[0];
  assign blen_sel   = field_q ? byte_act[3] : byte_act[1];

  assign vblank_out = in_span(32'(vcount), 32'(bstart_sel),
                              span_end(32'(bstart_sel), 32'(blen_sel)));
  assign de_out     = in_span(32'(hcount), 32'(hstart_act), 32'(hstop_act)) && !vblank_out;
endmodule

// File: rtl/actwin_chk.sv
module actwin_chk #(
  parameter int VCNT_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic              frame_start,
  input logic [15:0]       hcount,
  input logic [VCNT_W-1:0] vcount,
  input logic              de,
  input logic              vblank,
  input logic [15:0]       hstart_act,
  input logic [15:0]       hstop_act
);
  assert_hzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> hcount == 16'd0);

  assert_hstep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && hcount != 16'hFFFF) |=> hcount == $past(hcount) + 16'd1);

  assert_vzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> vcount == '0);

  assert_vhold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !line_start) |=> $stable(vcount));

  assert_blank_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vblank |-> !de);

  assert_bounds_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> ($stable(hstart_act) && $stable(hstop_act)));
endmodule

bind actwin_gen actwin_chk #(.VCNT_W(VCNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
  .hcount(hcount), .vcount(vcount), .de(de_out), .vblank(vblank_out),
  .hstart_act(hstart_act), .hstop_act(hstop_act)
);

// File: tb/actwin_gen_bench.sv
module actwin_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hsync_in = 1'b0, vsync_in = 1'b0, field_in = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic de_out, vblank_out;
  logic [15:0] hcount;
  logic [11:0] vcount;

  always #2.5 clk = ~clk;

  actwin_gen u_actwin_gen (
    .clk(clk), .rst_n(rst_n), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .field_in(field_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .de_out(de_out), .vblank_out(vblank_out), .hcount(hcount), .vcount(vcount)
  );

  int tests = 0, fails = 0, de_seen = 0;
  bit done = 0;

  typedef struct packed { logic de; logic vb; logic [15:0] h; logic [11:0] v; } exp_t;
  exp_t  exp_q[$];
  string tag_q[$];

  // bench-side view of the block, built from the requirements
  int m_h = 0, m_v = 0, m_fld = 0, hs_prev = 0, vs_prev = 0;
  int st_lo[2] = '{274 % 256, 1298 % 256};
  int p_w[2] = '{274, 1298}, a_w[2] = '{274, 1298};
  int p_b[4] = '{3, 30, 3, 30}, a_b[4] = '{3, 30, 3, 30};

  task automatic step(input bit hs, input bit vs, input bit fld,
                      input bit we, input int addr, input int data, input string tag);
    bit hsr, vsr; int bs, bl; exp_t e;
    hsync_in = hs; vsync_in = vs; field_in = fld;
    wr_en = we; wr_addr = 4'(addr); wr_data = 8'(data);
    hsr = hs && !hs_prev; vsr = vs && !vs_prev;
    if (hsr) begin a_w = p_w; a_b = p_b; end
    if (we) begin
      case (addr)
        0, 2: st_lo[addr/2] = data;
        1, 3: p_w[addr/2] = data * 256 + st_lo[addr/2];
        4, 5, 6, 7: p_b[addr-4] = data;
        default: ;
      endcase
    end
    m_h = hsr ? 0 : (m_h == 65535 ? m_h : m_h + 1);
    if (vsr) begin m_v = 0; m_fld = fld; end
    else if (hsr && m_v != 4095) m_v = m_v + 1;
    hs_prev = hs; vs_prev = vs;
    bs = m_fld ? a_b[2] : a_b[0];
    bl = m_fld ? a_b[3] : a_b[1];
    e.vb = (m_v >= bs) && (m_v < bs + bl);
    e.de = (m_h >= a_w[0]) && (m_h < a_w[1]) && !e.vb;
    e.h = 16'(m_h); e.v = 12'(m_v);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int data, input string tag);
    step(0, 0, 0, 1, addr, data, tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic line(input int total, input bit vs, input bit fld, input string tag);
    for (int i = 0; i < total; i++)
      step(i < 2, vs && i == 0, fld, 0, 0, 0, tag);
  endtask

  task automatic frame(input bit fld, input string tag);
    line(20, 1, fld, tag);
    for (int l = 0; l < 6; l++) line(20, 0, !fld, tag);
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        exp_t e; string t; bit bad;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        tests++; bad = 0;
        if (de_out) de_seen++;
        if (hcount !== e.h) begin bad = 1;
          $display("FAIL %s R1 hcount=%0d expected %0d", t, hcount, e.h); end
        if (vcount !== e.v) begin bad = 1;
          $display("FAIL %s R2 vcount=%0d expected %0d", t, vcount, e.v); end
        if (de_out !== e.de) begin bad = 1;
          $display("FAIL %s R3 de=%0b expected %0b at h=%0d", t, de_out, e.de, e.h); end
        if (vblank_out !== e.vb) begin bad = 1;
          $display("FAIL %s R4 vblank=%0b expected %0b at v=%0d", t, vblank_out, e.vb, e.v); end
        if (bad) fails++;
      end
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    check(hcount == 0 && vcount == 0, "R9 counters", int'(hcount) + int'(vcount), 0);
    check(de_out == 0, "R9 de", int'(de_out), 0);
    check(vblank_out == 0, "R9 vblank", int'(vblank_out), 0);

    // R9/R3: reset bounds give 1024 enabled pixels on a 1328 line
    de_seen = 0;
    line(1328, 1, 0, "R9");
    check(de_seen == 1024, "R3 de count per line", de_seen, 1024);

    // R5: map plus ignored addresses (8, 9 and 15 would alias if decode were short)
    wr(0, 4, "R5"); wr(8, 8'hFF, "R5"); wr(9, 5, "R5"); wr(1, 0, "R5");
    wr(2, 12, "R5"); wr(3, 0, "R5");
    wr(4, 2, "R5"); wr(5, 3, "R5"); wr(6, 1, "R5"); wr(7, 2, "R5");
    wr(15, 8'h7F, "R5");

    // R4: per-field blanking; field flag toggles on non-sync lines
    frame(0, "R4");
    frame(1, "R4");

    // R6: lone low-byte write to stop leaves window 4..11 intact
    wr(2, 2, "R6");
    line(20, 0, 0, "R6");
    wr(2, 12, "R6");

    // R7: high byte alone reuses staged low byte
    wr(0, 6, "R7"); wr(1, 1, "R7");
    line(20, 0, 0, "R7");
    wr(1, 0, "R7");
    line(20, 0, 0, "R7");
    line(20, 0, 0, "R7");

    // R8: commit inside the window keeps old stop for the rest of the line
    line(6, 0, 0, "R8");
    wr(2, 8, "R8"); wr(3, 0, "R8");
    idle(12, "R8");
    line(20, 0, 0, "R8");

    @(posedge clk); #2;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule